// File: doc/BRIEF.md
# Character Display Timing Generator

This block produces the raster timing and addressing for a character-based text display. A host programs sixteen byte-wide parameter registers through two locations. Writing the first location selects a register and writing the second stores a value into it. The block then produces horizontal and vertical sync, a display-enable window, a character memory address, the scanline number within the current character row, and a cursor strobe. Character generation, pixel serialisation and the video memory are outside the block and sit downstream of these outputs.

One character position passes per clock. The horizontal counter counts the positions of a line. A two-state vertical machine counts character rows and then any extra adjustment scanlines. In state `ROWS` the machine counts scanlines within each character row and character rows within the frame. On the event `ROWS_DONE` it moves to `ADJUST` when extra lines are programmed, or takes `FRAME_WRAP` straight back to `ROWS` when none are. In `ADJUST` it counts the extra scanlines and takes `FRAME_WRAP` back to `ROWS` after the last one. Each `FRAME_WRAP` reloads the memory address from the programmed start address and advances a field counter that drives the cursor blink.

After reset the registers describe an 80-by-25 text screen with eight scanlines per character row and a slowly blinking cursor.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset the registers hold: index 0 = 109, 1 = 80, 2 = 89, 3 = 12, 4 = 31, 5 = 2, 6 = 24, 7 = 26, 8 = 0, 9 = 7, 10 = 60h, 11 = 7, and 0 for indices 12 to 15. With these values, hsync first rises 89 clocks after reset and vsync first rises 22880 clocks after reset.
- R2: A write with `host_rs`=0 latches the register index from `host_wdata[3:0]`. A write with `host_rs`=1 stores `host_wdata` into the selected register, masked to its width: index 3 keeps 4 bits; indices 5, 9 and 11 keep 5 bits; indices 12 and 14 keep 6 bits; indices 4, 6, 7 and 10 keep 7 bits; index 8 keeps 2 bits. `host_rdata` returns the stored value when `host_rs`=1 and the index is 14 or 15, and returns 0 in every other case.
- R3: A line lasts (reg0 + 1) clocks.
- R4: `disp_en` is high while the column count is below reg1 and the character row is below reg6. It is low throughout the adjustment lines.
- R5: `hsync` is high from column reg2 for reg3[3:0] clocks.
- R6: A frame lasts (reg4 + 1) × (reg9 + 1) + reg5[4:0] lines.
- R7: `vsync` rises on the first scanline of character row reg7 and stays high for exactly 16 lines.
- R8: `row_addr` counts 0 to reg9 within each character row. It counts 0 to reg5 − 1 during the adjustment lines.
- R9: `mem_addr` is {reg12[5:0], reg13} at the first displayed character of a frame. It rises by one per column. Each character row starts reg1 above the previous row's start.
- R10: `cursor` is high on a displayed character whose `mem_addr` equals {reg14[5:0], reg15} and whose `row_addr` lies between reg10[4:0] and reg11[4:0] inclusive.
- R11: reg10[6:5] selects the cursor mode: 00 steady, 01 never shown, 10 visible for 8 frames then hidden for 8, 11 visible for 16 frames then hidden for 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_rs | input | 1 | 0 = index latch, 1 = register data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Active display window |
| mem_addr | output | 14 | Character memory address |
| row_addr | output | 5 | Scanline within character row |
| cursor | output | 1 | Cursor strobe |

## Verification
All display outputs are decoded combinationally from counters that advance on each clock edge. A result therefore appears in the same clock period as the counter state that produces it. The bench samples it on the falling edge that follows the rising edge that moved the counters. A register write takes effect one edge after the data write, and reads are combinational, so a read-back is sampled within the read cycle. Timing checks align on a vsync rise, whose position is known from R7, and then step a model of column and line forward one falling edge at a time.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 16;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] IDX_CUR_HI = 4'd14;
    localparam logic [IDX_W-1:0] IDX_CUR_LO = 4'd15;

    typedef enum logic [0:0] {
        VS_ROWS   = 1'b0,
        VS_ADJUST = 1'b1
    } vstate_e;

    typedef enum logic [1:0] {
        CUR_STEADY  = 2'b00,
        CUR_OFF     = 2'b01,
        CUR_BLINK16 = 2'b10,
        CUR_BLINK32 = 2'b11
    } cur_mode_e;

    function automatic logic [REG_W-1:0] reg_default(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 8'd109;
            4'd1:    return 8'd80;
            4'd2:    return 8'd89;
            4'd3:    return 8'd12;
            4'd4:    return 8'd31;
            4'd5:    return 8'd2;
            4'd6:    return 8'd24;
            4'd7:    return 8'd26;
            4'd9:    return 8'd7;
            4'd10:   return 8'h60;
            4'd11:   return 8'd7;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reg_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd3:                      return 8'h0F;
            4'd5, 4'd9, 4'd11:         return 8'h1F;
            4'd12, 4'd14:              return 8'h3F;
            4'd4, 4'd6, 4'd7, 4'd10:   return 8'h7F;
            4'd8:                      return 8'h03;
            default:                   return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic                               rs,
    input  logic [REG_W-1:0]                   wdata,
    output logic [REG_W-1:0]                   rdata,
    output logic [NUM_REGS-1:0][REG_W-1:0]     regs
);

    logic [IDX_W-1:0] sel;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[REG_W-1:IDX_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= reg_default(IDX_W'(i));
            end
        end else if (we) begin
            if (!rs) begin
                sel <= wdata[IDX_W-1:0];
            end else begin
                regs[sel] <= wdata & reg_mask(sel);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rs && (sel == IDX_CUR_HI || sel == IDX_CUR_LO)) begin
            rdata = regs[sel];
        end
    end

    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));

endmodule

// File: rtl/crtc_htiming.sv
module crtc_htiming #(
    parameter int HW    = 8,
    parameter int HSW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    htotal,
    input  logic [HW-1:0]    hdisp,
    input  logic [HW-1:0]    hs_pos,
    input  logic [HSW_W-1:0] hs_wid,
    output logic [HW-1:0]    hcnt,
    output logic             line_end,
    output logic             h_disp,
    output logic             hsync
);

    logic [HW:0] hs_offs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + HW'(1);
        end
    end

    always_comb begin
        line_end = (hcnt >= htotal);
        h_disp   = (hcnt < hdisp);
        hs_offs  = {1'b0, hcnt} - {1'b0, hs_pos};
        hsync    = (hcnt >= hs_pos) && (hs_offs < (HW+1)'(hs_wid));
    end

    p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> hcnt == '0);

    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> hcnt == $past(hcnt) + HW'(1));

    p_hs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) && $stable(hs_pos) && $stable(hs_wid) |-> hcnt == hs_pos);

endmodule

// File: rtl/crtc_vtiming.sv
module crtc_vtiming
    import crtc_pkg::*;
#(
    parameter int ROW_W    = 7,
    parameter int RA_W     = 5,
    parameter int MA_W     = 14,
    parameter int HW       = 8,
    parameter int VS_LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [ROW_W-1:0] vtotal,
    input  logic [ROW_W-1:0] vdisp,
    input  logic [ROW_W-1:0] vs_pos,
    input  logic [RA_W-1:0]  vadj,
    input  logic [RA_W-1:0]  max_ra,
    input  logic [HW-1:0]    hdisp,
    input  logic [MA_W-1:0]  start_addr,
    output logic [RA_W-1:0]  ra,
    output logic [MA_W-1:0]  row_base,
    output logic             v_disp,
    output logic             vsync,
    output logic             frame_start
);

    localparam int VS_W = $clog2(VS_LINES + 1);

    vstate_e           state, state_n;
    logic [ROW_W-1:0]  row, row_n;
    logic [RA_W-1:0]   ra_n;
    logic [MA_W-1:0]   base_n;
    logic [VS_W-1:0]   vs_cnt, vs_n;
    logic              wrap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= VS_ROWS;
            row      <= '0;
            ra       <= '0;
            row_base <= '0;
            vs_cnt   <= '0;
        end else begin
            state    <= state_n;
            row      <= row_n;
            ra       <= ra_n;
            row_base <= base_n;
            vs_cnt   <= vs_n;
        end
    end

    // Next state: ROWS_DONE leads to ADJUST or FRAME_WRAP
    always_comb begin
        state_n = state;
        row_n   = row;
        ra_n    = ra;
        base_n  = row_base;
        wrap    = 1'b0;
        if (line_end) begin
            unique case (state)
                VS_ROWS: begin
                    if (ra >= max_ra) begin
                        ra_n = '0;
                        if (row >= vtotal) begin
                            if (vadj == '0) begin
                                wrap = 1'b1;
                            end else begin
                                state_n = VS_ADJUST;
                            end
                        end else begin
                            row_n  = row + ROW_W'(1);
                            base_n = row_base + MA_W'(hdisp);
                        end
                    end else begin
                        ra_n = ra + RA_W'(1);
                    end
                end
                VS_ADJUST: begin
                    if ((RA_W+1)'(ra) + (RA_W+1)'(1) >= (RA_W+1)'(vadj)) begin
                        wrap = 1'b1;
                    end else begin
                        ra_n = ra + RA_W'(1);
                    end
                end
                default: wrap = 1'b1;
            endcase
            if (wrap) begin
                state_n = VS_ROWS;
                row_n   = '0;
                ra_n    = '0;
                base_n  = start_addr;
            end
        end
    end

    always_comb begin
        vs_n = vs_cnt;
        if (line_end) begin
            if (state_n == VS_ROWS && row_n == vs_pos && ra_n == '0) begin
                vs_n = VS_W'(VS_LINES);
            end else if (vs_cnt != '0) begin
                vs_n = vs_cnt - VS_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        v_disp      = (state == VS_ROWS) && (row < vdisp);
        vsync       = (vs_cnt != '0);
        frame_start = wrap;
    end

    p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state == VS_ROWS && row == '0 && ra == '0));

    p_ra_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && state == VS_ROWS && ra >= max_ra) |=> ra == '0);

    p_ra_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(ra));

    p_vs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) && $stable(vs_pos) |-> (state == VS_ROWS && row == vs_pos && ra == '0));

endmodule

// File: rtl/crtc_cursor.sv
module crtc_cursor
    import crtc_pkg::*;
#(
    parameter int MA_W = 14,
    parameter int RA_W = 5,
    parameter int HW   = 8,
    parameter int FC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            disp_en,
    input  logic [MA_W-1:0] row_base,
    input  logic [HW-1:0]   hcnt,
    input  logic [RA_W-1:0] ra,
    input  logic [1:0]      mode_bits,
    input  logic [RA_W-1:0] cur_first,
    input  logic [RA_W-1:0] cur_last,
    input  logic [MA_W-1:0] cur_addr,
    output logic [MA_W-1:0] mem_addr,
    output logic            cursor
);

    cur_mode_e       mode;
    logic [FC_W-1:0] fcnt;
    logic            blink_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (frame_start) begin
            fcnt <= fcnt + FC_W'(1);
        end
    end

    always_comb begin
        mode     = cur_mode_e'(mode_bits);
        mem_addr = row_base + MA_W'(hcnt);
        unique case (mode)
            CUR_STEADY:  blink_on = 1'b1;
            CUR_OFF:     blink_on = 1'b0;
            CUR_BLINK16: blink_on = !fcnt[FC_W-2];
            CUR_BLINK32: blink_on = !fcnt[FC_W-1];
            default:     blink_on = 1'b0;
        endcase
        cursor = disp_en && blink_on && (mem_addr == cur_addr)
                 && (ra >= cur_first) && (ra <= cur_last);
    end

    p_field_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> fcnt == $past(fcnt) + FC_W'(1));

    p_field_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(fcnt));

    p_cursor_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CUR_OFF) |-> !cursor);

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int HW       = 8,
    parameter int ROW_W    = 7,
    parameter int RA_W     = 5,
    parameter int MA_W     = 14,
    parameter int VS_LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_rs,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             hsync,
    output logic             vsync,
    output logic             disp_en,
    output logic [MA_W-1:0]  mem_addr,
    output logic [RA_W-1:0]  row_addr,
    output logic             cursor
);

    localparam int HSW_W = 4;
    localparam int MA_HI = MA_W - REG_W;

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [HW-1:0]   hcnt;
    logic            line_end, h_disp, v_disp, frame_start;
    logic [MA_W-1:0] row_base;
    logic            unused_reg_bits;

    assign unused_reg_bits = ^{regs[3][7:4], regs[4][7], regs[5][7:5], regs[6][7],
                               regs[7][7], regs[8], regs[9][7:5], regs[10][7],
                               regs[11][7:5], regs[12][7:6], regs[14][7:6]};

    crtc_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .rs    (host_rs),
        .wdata (host_wdata),
        .rdata (host_rdata),
        .regs  (regs)
    );

    crtc_htiming #(.HW(HW), .HSW_W(HSW_W)) u_htim (
        .clk      (clk),
        .rst_n    (rst_n),
        .htotal   (regs[0][HW-1:0]),
        .hdisp    (regs[1][HW-1:0]),
        .hs_pos   (regs[2][HW-1:0]),
        .hs_wid   (regs[3][HSW_W-1:0]),
        .hcnt     (hcnt),
        .line_end (line_end),
        .h_disp   (h_disp),
        .hsync    (hsync)
    );

    crtc_vtiming #(.ROW_W(ROW_W), .RA_W(RA_W), .MA_W(MA_W), .HW(HW), .VS_LINES(VS_LINES)) u_vtim (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end    (line_end),
        .vtotal      (regs[4][ROW_W-1:0]),
        .vdisp       (regs[6][ROW_W-1:0]),
        .vs_pos      (regs[7][ROW_W-1:0]),
        .vadj        (regs[5][RA_W-1:0]),
        .max_ra      (regs[9][RA_W-1:0]),
        .hdisp       (regs[1][HW-1:0]),
        .start_addr  ({regs[12][MA_HI-1:0], regs[13]}),
        .ra          (row_addr),
        .row_base    (row_base),
        .v_disp      (v_disp),
        .vsync       (vsync),
        .frame_start (frame_start)
    );

    assign disp_en = h_disp && v_disp;

    crtc_cursor #(.MA_W(MA_W), .RA_W(RA_W), .HW(HW)) u_cur (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .disp_en     (disp_en),
        .row_base    (row_base),
        .hcnt        (hcnt),
        .ra          (row_addr),
        .mode_bits   (regs[10][6:5]),
        .cur_first   (regs[10][RA_W-1:0]),
        .cur_last    (regs[11][RA_W-1:0]),
        .cur_addr    ({regs[14][MA_HI-1:0], regs[15]}),
        .mem_addr    (mem_addr),
        .cursor      (cursor)
    );

endmodule

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_rs = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        hsync, vsync, disp_en, cursor;
    logic [13:0] mem_addr;
    logic [4:0]  row_addr;

    int vectors = 0;
    int miscompares = 0;
    int prints = 0;
    int cyc = 0;
    int wd = 0;
    bit done = 0;

    // {index, write value, expected read-back}
    localparam logic [23:0] PROG [16] = '{
        {8'd0,  8'd19,  8'd0}, {8'd1,  8'd12,  8'd0}, {8'd2,  8'd14,  8'd0},
        {8'd3,  8'd3,   8'd0}, {8'd4,  8'd5,   8'd0}, {8'd5,  8'd2,   8'd0},
        {8'd6,  8'd4,   8'd0}, {8'd7,  8'd1,   8'd0}, {8'd8,  8'd0,   8'd0},
        {8'd9,  8'd3,   8'd0}, {8'd10, 8'h01,  8'd0}, {8'd11, 8'd2,   8'd0},
        {8'd12, 8'h01,  8'd0}, {8'd13, 8'h00,  8'd0}, {8'd14, 8'h41,  8'h01},
        {8'd15, 8'h0D,  8'h0D}
    };

    crtc_timing_gen u_crtc_timing_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_rs    (host_rs),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .hsync      (hsync),
        .vsync      (vsync),
        .disp_en    (disp_en),
        .mem_addr   (mem_addr),
        .row_addr   (row_addr),
        .cursor     (cursor)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            if (prints < 25) begin
                prints++;
                $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic host_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); host_we = 1'b1; host_rs = 1'b0; host_wdata = idx;
        @(negedge clk); host_rs = 1'b1; host_wdata = val;
        @(negedge clk); host_we = 1'b0; host_rs = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] idx, output logic [7:0] val);
        @(negedge clk); host_we = 1'b1; host_rs = 1'b0; host_wdata = idx;
        @(negedge clk); host_we = 1'b0; host_rs = 1'b1;
        #1 val = host_rdata;
    endtask

    task automatic to_vsync_rise();
        while (vsync) step();
        while (!vsync) step();
    endtask

    task automatic frame_seen(output bit seen);
        seen = 1'b0;
        while (vsync) begin step(); if (cursor) seen = 1'b1; end
        while (!vsync) begin step(); if (cursor) seen = 1'b1; end
    endtask

    task automatic blink_run(output int run);
        bit a, b;
        run = 0;
        frame_seen(a);
        for (int k = 0; k < 40; k++) begin
            frame_seen(b);
            if (b != a) break;
            a = b;
        end
        run = 1;
        for (int k = 0; k < 40; k++) begin
            frame_seen(a);
            if (a != b) break;
            run++;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 190000 && !done) begin
                vectors++;
                miscompares++;
                $display("FAIL R3 watchdog actual=%0d expected<190000", wd);
                summary();
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd;
        int t0, w, dcount, run;
        int h, line, row_e, ra_e, addr_e;
        bit disp_e, cur_e;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;

        // Reset state (R1): column 0, row 0, cursor at address 0 on scanline 0
        check("R1", "reset hsync", hsync, 0);
        check("R1", "reset vsync", vsync, 0);
        check("R4", "reset disp_en", disp_en, 1);
        check("R9", "reset mem_addr", mem_addr, 0);
        check("R8", "reset row_addr", row_addr, 0);
        check("R10", "reset cursor", cursor, 1);

        // Default horizontal timing
        while (!hsync) step();
        check("R1", "first hsync rise cycle", cyc, 89);
        t0 = cyc; w = 0; dcount = 0;
        while (hsync) begin w++; if (disp_en) dcount++; step(); end
        check("R5", "default hsync width", w, 12);
        while (!hsync) begin if (disp_en) dcount++; step(); end
        check("R3", "default line length", cyc - t0, 110);
        check("R4", "default displayed columns", dcount, 80);

        // Default vertical timing
        while (!vsync) step();
        check("R1", "first vsync rise cycle", cyc, 22880);
        t0 = cyc; w = 0;
        while (vsync) begin w++; step(); end
        check("R7", "default vsync width", w, 16 * 110);
        while (!vsync) step();
        check("R6", "default frame length", cyc - t0, 258 * 110);

        // Read-back before programming
        host_read(8'd15, rd);
        check("R1", "reset cursor reg read", rd, 0);

        // Programming table with read-back (R2)
        for (int i = 0; i < 16; i++) begin
            host_write(PROG[i][23:16], PROG[i][15:8]);
            host_read(PROG[i][23:16], rd);
            check("R2", $sformatf("read-back index %0d", i), rd, PROG[i][7:0]);
        end
        @(negedge clk); host_rs = 1'b0;
        #1 check("R2", "latch-port read", host_rdata, 0);
        host_rs = 1'b0;

        // Small geometry: 20 columns, 6 rows of 4 lines, 2 adjust lines
        to_vsync_rise();
        h = 0; line = 4;
        for (int n = 0; n < 2 * 26 * 20; n++) begin
            row_e  = line / 4;
            ra_e   = (line < 24) ? (line % 4) : (line - 24);
            disp_e = (line < 16) && (h < 12);
            addr_e = 256 + row_e * 12 + h;
            cur_e  = disp_e && (addr_e == 269) && (ra_e >= 1) && (ra_e <= 2);
            check("R4", "disp_en", disp_en, disp_e);
            check("R5", "hsync", hsync, (h >= 14 && h < 17));
            check("R7", "vsync", vsync, (line >= 4 && line < 20));
            check("R8", "row_addr", row_addr, ra_e);
            if (disp_e) check("R9", "mem_addr", mem_addr, addr_e);
            check("R10", "cursor", cursor, cur_e);
            step();
            h++;
            if (h == 20) begin
                h = 0;
                line = (line + 1) % 26;
            end
        end
        while (!vsync) step();
        check("R6", "frame boundary at vsync", (h == 0 && line == 4), 1);

        // Cursor mode 01: hidden
        host_write(8'd10, 8'h21);
        to_vsync_rise();
        frame_seen(cur_e);
        check("R11", "mode 01 frame 1 cursor", cur_e, 0);
        frame_seen(cur_e);
        check("R11", "mode 01 frame 2 cursor", cur_e, 0);

        // Cursor mode 10: 8-frame phases
        host_write(8'd10, 8'h41);
        to_vsync_rise();
        blink_run(run);
        check("R11", "mode 10 phase length", run, 8);

        // Cursor mode 11: 16-frame phases
        host_write(8'd10, 8'h61);
        to_vsync_rise();
        blink_run(run);
        check("R11", "mode 11 phase length", run, 16);

        done = 1;
        summary();
        $finish;
    end

endmodule